// File: doc/BRIEF.md
# Bus Address Region Classifier

This block sits next to a data cache controller and sorts every load or store into one of three classes. The first class is a hit in a local scratchpad window. The second is a cacheable access to the external bus. The third is a non-cacheable access to the external bus. A programmable 8-bit window base picks one 16 MB region of the 32-bit address space. Any access inside that region is served by a small on-chip RAM with no wait states, and it never appears on the external bus. The RAM is only a few kilobytes, so every address in the 16 MB window folds onto it. All other accesses go to the bus on the same cycle. Their cacheability comes from a 16-bit segment mask, with one bit for each 256 MB segment. When the mask is all zeros, a cacheability input from elsewhere in the system is used instead.

Every request gets a registered response one cycle later. A small response state machine produces it, with these states:
- `RSP_IDLE`: no request was accepted in the last cycle.
- `RSP_SPAD_RD`: a scratchpad load is returning data.
- `RSP_SPAD_WR`: a scratchpad store has completed.
- `RSP_BUS`: the access was forwarded to the bus.

On each clock edge, the machine moves to one of these states as follows:
- With no request, it goes to `RSP_IDLE`.
- A request that hits the window goes to `RSP_SPAD_RD` for a load or `RSP_SPAD_WR` for a store.
- Any other request goes to `RSP_BUS`.

These transitions are taken from every state, so back-to-back requests are handled on consecutive cycles.

Top module: `addr_region_classifier`

## Requirements
- R1: After reset the window base is 0x8F, so addresses 0x8F000000–0x8FFFFFFF hit the scratchpad, and `rsp_valid` is 0.
- R2: When `cfg_mask` is nonzero, bit n of it (bit 0 = lowest) gives the cacheability of addresses whose bits [31:28] equal n. A set bit means cacheable, reported on `bus_req_cacheable` and one cycle later on `rsp_cacheable`. For example, mask 0x00F3 makes 0x00000000–0x1FFFFFFF and 0x40000000–0x7FFFFFFF cacheable and every other segment non-cacheable.
- R3: When `cfg_mask` is zero, a non-scratchpad access takes its cacheability from `ext_cacheable`.
- R4: An access whose bits [31:24] equal the window base is a scratchpad hit. For a hit, `bus_req_valid` stays 0, and the next cycle shows `rsp_spad`=1 and `rsp_cacheable`=0, whatever the mask says.
- R5: A non-scratchpad request appears on the bus port in the same cycle, with identical address, write flag, write data and byte enables, and with `bus_req_valid`=1.
- R6: A scratchpad store writes only the bytes whose `req_be` bit is set, where bit i selects data bits [8i+7:8i].
- R7: A scratchpad load returns the stored word on `rsp_rdata` in the cycle after the request.
- R8: The RAM word is selected by address bits [IDX_W+1:2]. Two window addresses that differ only above those bits reach the same word.
- R9: A write of a nonzero value through `cfg_base_we`/`cfg_base_wdata` moves the window from the next cycle on. A write of 0 is ignored, and the previous base stays.
- R10: `rsp_valid` is 1 for exactly the cycle after each accepted request and 0 otherwise. `rsp_rdata` is 0 except for scratchpad loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mask | input | 16 | Per-256 MB cacheability mask, 0 = use fallback |
| ext_cacheable | input | 1 | Fallback cacheability indication |
| cfg_base_we | input | 1 | Window base write strobe |
| cfg_base_wdata | input | 8 | New window base (address bits 31:24) |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_spad | output | 1 | Response was a scratchpad access |
| rsp_cacheable | output | 1 | Classified cacheability of the request |
| rsp_rdata | output | 32 | Scratchpad load data |
| bus_req_valid | output | 1 | Forwarded bus request valid |
| bus_req_write | output | 1 | Forwarded store flag |
| bus_req_addr | output | 32 | Forwarded address |
| bus_req_wdata | output | 32 | Forwarded store data |
| bus_req_be | output | 4 | Forwarded byte enables |
| bus_req_cacheable | output | 1 | Cacheability of forwarded request |

## Verification
Random addresses across all sixteen segments are run with random masks, both zero and nonzero. Varying the fallback input alongside them shows whether the mask or `ext_cacheable` decided each result. Window-biased addresses with random byte enables, checked against a shadow copy of the RAM, expose byte-lane mistakes and wrong index bits. Directed cases cover several points:
- the 0x00F3 segment edges;
- an alias pair a full RAM size apart;
- a base move to 0x12;
- a zero base write, which must leave the old window active.

Together these separate window priority from segment decoding.

// File: rtl/arc_pkg.sv
package arc_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned SEG_W    = 4;
    localparam int unsigned NSEG     = 1 << SEG_W;
    localparam int unsigned WIN_W    = 8;

    typedef enum logic [1:0] {
        RSP_IDLE    = 2'd0,
        RSP_SPAD_RD = 2'd1,
        RSP_SPAD_WR = 2'd2,
        RSP_BUS     = 2'd3
    } rsp_state_t;
endpackage

// File: rtl/arc_base_reg.sv
module arc_base_reg
    import arc_pkg::*;
#(
    parameter logic [WIN_W-1:0] BASE_RST = 8'h8F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIN_W-1:0] wdata,
    output logic [WIN_W-1:0] base
);
    logic [WIN_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
        end else if (we && (wdata != '0)) begin
            base_q <= wdata;
        end
    end

    assign base = base_q;

    AST_BASE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        base_q != '0); // R9

    AST_ZERO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata == '0) |=> $stable(base_q)); // R9
endmodule

// File: rtl/arc_decoder.sv
module arc_decoder
    import arc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIN_W-1:0]  base,
    input  logic [NSEG-1:0]   mask,
    input  logic              ext_cacheable,
    output logic              spad_hit,
    output logic              cacheable
);
    logic [SEG_W-1:0] seg;
    logic             seg_bit;

    always_comb begin
        seg      = addr[ADDR_W-1 -: SEG_W];
        seg_bit  = mask[seg];
        spad_hit = (addr[ADDR_W-1 -: WIN_W] == base);
        if (spad_hit) begin
            cacheable = 1'b0;
        end else if (mask == '0) begin
            cacheable = ext_cacheable;
        end else begin
            cacheable = seg_bit;
        end
    end
endmodule

// File: rtl/arc_spad_ram.sv
module arc_spad_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 512,
    localparam int unsigned BYTES = DATA_W / 8,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTES-1:0]  be,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < int'(BYTES); b++) begin
                if (be[b]) begin
                    mem[idx][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
        if (rd_en) begin
            rdata_q <= mem[idx];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/arc_rsp_fsm.sv
module arc_rsp_fsm
    import arc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              spad_hit,
    input  logic              cacheable,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              rsp_valid,
    output logic              rsp_spad,
    output logic              rsp_cacheable,
    output logic [DATA_W-1:0] rsp_rdata
);
    rsp_state_t state_q, state_d;
    logic       cache_q;

    always_comb begin
        if (!req_valid) begin
            state_d = RSP_IDLE;
        end else if (spad_hit) begin
            state_d = req_write ? RSP_SPAD_WR : RSP_SPAD_RD;
        end else begin
            state_d = RSP_BUS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            cache_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cache_q <= req_valid && cacheable;
        end
    end

    always_comb begin
        rsp_valid     = 1'b0;
        rsp_spad      = 1'b0;
        rsp_cacheable = 1'b0;
        rsp_rdata     = '0;
        unique case (state_q)
            RSP_IDLE: begin
            end
            RSP_SPAD_RD: begin
                rsp_valid = 1'b1;
                rsp_spad  = 1'b1;
                rsp_rdata = ram_rdata;
            end
            RSP_SPAD_WR: begin
                rsp_valid = 1'b1;
                rsp_spad  = 1'b1;
            end
            RSP_BUS: begin
                rsp_valid     = 1'b1;
                rsp_cacheable = cache_q;
            end
            default: begin
            end
        endcase
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10

    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10

    AST_SPAD_RSP_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_spad |-> !rsp_cacheable); // R4
endmodule

// File: rtl/addr_region_classifier.sv
module addr_region_classifier
    import arc_pkg::*;
#(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      SPAD_KB  = 2,
    parameter logic [WIN_W-1:0] BASE_RST = 8'h8F,
    localparam int unsigned     BYTES    = DATA_W / 8,
    localparam int unsigned     OFF_W    = $clog2(BYTES),
    localparam int unsigned     WORDS    = SPAD_KB * 1024 / BYTES,
    localparam int unsigned     IDX_W    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSEG-1:0]   cfg_mask,
    input  logic              ext_cacheable,
    input  logic              cfg_base_we,
    input  logic [WIN_W-1:0]  cfg_base_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BYTES-1:0]  req_be,
    output logic              rsp_valid,
    output logic              rsp_spad,
    output logic              rsp_cacheable,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req_valid,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    output logic [BYTES-1:0]  bus_req_be,
    output logic              bus_req_cacheable
);
    logic [WIN_W-1:0]  base;
    logic              spad_hit;
    logic              cacheable;
    logic [DATA_W-1:0] ram_rdata;
    logic [IDX_W-1:0]  ram_idx;

    arc_base_reg #(.BASE_RST(BASE_RST)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_base_we),
        .wdata (cfg_base_wdata),
        .base  (base)
    );

    arc_decoder u_dec (
        .addr          (req_addr),
        .base          (base),
        .mask          (cfg_mask),
        .ext_cacheable (ext_cacheable),
        .spad_hit      (spad_hit),
        .cacheable     (cacheable)
    );

    assign ram_idx = req_addr[OFF_W +: IDX_W];

    arc_spad_ram #(.DATA_W(DATA_W), .WORDS(WORDS)) u_ram (
        .clk   (clk),
        .wr_en (req_valid && spad_hit && req_write),
        .rd_en (req_valid && spad_hit && !req_write),
        .idx   (ram_idx),
        .wdata (req_wdata),
        .be    (req_be),
        .rdata (ram_rdata)
    );

    arc_rsp_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .spad_hit      (spad_hit),
        .cacheable     (cacheable),
        .ram_rdata     (ram_rdata),
        .rsp_valid     (rsp_valid),
        .rsp_spad      (rsp_spad),
        .rsp_cacheable (rsp_cacheable),
        .rsp_rdata     (rsp_rdata)
    );

    always_comb begin
        bus_req_valid     = req_valid && !spad_hit;
        bus_req_write     = req_write;
        bus_req_addr      = req_addr;
        bus_req_wdata     = req_wdata;
        bus_req_be        = req_be;
        bus_req_cacheable = bus_req_valid && cacheable;
    end

    AST_SPAD_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1 -: WIN_W] == base) |-> !bus_req_valid); // R4

    AST_MASK_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && cfg_mask == '0) |-> (bus_req_cacheable == ext_cacheable)); // R3

    AST_SEGMENT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && cfg_mask != '0)
            |-> (bus_req_cacheable == cfg_mask[req_addr[ADDR_W-1 -: SEG_W]])); // R2

    AST_FORWARD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_addr == req_addr && bus_req_be == req_be)); // R5
endmodule

// File: tb/addr_region_classifier_bench.sv
module addr_region_classifier_bench;
    localparam int WORDS = 512;
    localparam int IDX_W = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_mask = '0;
    logic        ext_cacheable = 1'b0;
    logic        cfg_base_we = 1'b0;
    logic [7:0]  cfg_base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid, rsp_spad, rsp_cacheable;
    logic [31:0] rsp_rdata;
    logic        bus_req_valid, bus_req_write, bus_req_cacheable;
    logic [31:0] bus_req_addr, bus_req_wdata;
    logic [3:0]  bus_req_be;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [7:0]  m_base = 8'h8F;
    logic [31:0] shadow [WORDS];

    always #2.5 clk = ~clk;

    addr_region_classifier u_addr_region_classifier (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .ext_cacheable(ext_cacheable),
        .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_spad(rsp_spad), .rsp_cacheable(rsp_cacheable),
        .rsp_rdata(rsp_rdata), .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata), .bus_req_be(bus_req_be),
        .bus_req_cacheable(bus_req_cacheable)
    );

    function automatic bit exp_hit(logic [31:0] a);
        return a[31:24] == m_base;
    endfunction

    function automatic bit exp_cache(logic [31:0] a);
        if (exp_hit(a)) return 1'b0;
        if (cfg_mask == 16'h0) return ext_cacheable;
        return cfg_mask[a[31:28]];
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One access: drive at negedge, check bus port, check response a cycle later.
    task automatic access(bit wr, logic [31:0] a, logic [31:0] d, logic [3:0] be);
        bit          hit = exp_hit(a);
        bit          cach = exp_cache(a);
        logic [31:0] rd_exp = 32'h0;
        int          ix = int'(a[IDX_W+1:2]);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        check("R4/R5 bus_req_valid", 32'(bus_req_valid), 32'(!hit));
        if (!hit) begin
            check("R5 bus_req_addr", bus_req_addr, a);
            check("R5 bus_req_wdata", bus_req_wdata, d);
            check("R5 bus_req_be/write", {27'h0, bus_req_be, bus_req_write}, {27'h0, be, wr});
            check("R2/R3 bus_req_cacheable", 32'(bus_req_cacheable), 32'(cach));
        end
        if (hit && wr) shadow[ix] = merge(shadow[ix], d, be); // R6, R8
        if (hit && !wr) rd_exp = shadow[ix];                   // R7, R8
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 rsp_valid", 32'(rsp_valid), 32'h1);
        check("R4 rsp_spad", 32'(rsp_spad), 32'(hit));
        check("R2/R4 rsp_cacheable", 32'(rsp_cacheable), 32'(cach));
        check("R7/R10 rsp_rdata", rsp_rdata, rd_exp);
    endtask

    task automatic set_base(logic [7:0] v);
        cfg_base_we = 1'b1; cfg_base_wdata = v;
        @(negedge clk);
        cfg_base_we = 1'b0;
        if (v != 8'h0) m_base = v; // R9
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
        // R1: default window 0x8F
        req_valid = 1'b1; req_addr = 32'h8F00_0000; #1;
        check("R1 default window hit", 32'(bus_req_valid), 32'h0);
        req_addr = 32'h8E00_0000; #1;
        check("R1 outside default window", 32'(bus_req_valid), 32'h1);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 rsp_valid idle", 32'(rsp_valid), 32'h0);

        // R6 fill scratchpad
        for (int i = 0; i < WORDS; i++) access(1'b1, 32'h8F00_0000 + 32'(i*4), $urandom, 4'hF);

        // R2 mask 0x00F3 segment edges
        cfg_mask = 16'h00F3;
        access(1'b0, 32'h1FFF_FFFC, 0, 0);
        access(1'b0, 32'h2000_0000, 0, 0);
        access(1'b0, 32'h4000_0000, 0, 0);
        access(1'b0, 32'h7FFF_FFFC, 0, 0);
        access(1'b0, 32'h8000_0000, 0, 0);
        access(1'b1, 32'hF000_0000, 32'hDEAD_BEEF, 4'h5);
        // R4: window beats mask
        cfg_mask = 16'hFFFF;
        access(1'b0, 32'h8F12_3450, 0, 0);
        // R3 fallback
        cfg_mask = 16'h0;
        ext_cacheable = 1'b1; access(1'b0, 32'h3000_0000, 0, 0);
        ext_cacheable = 1'b0; access(1'b0, 32'h3000_0000, 0, 0);
        // R6 partial byte enables then read
        access(1'b1, 32'h8F00_0010, 32'hA1B2_C3D4, 4'b0110);
        access(1'b0, 32'h8F00_0010, 0, 0);
        // R8 alias a full RAM size away
        access(1'b1, 32'h8F00_0020 + 32'(WORDS*4), 32'h1357_9BDF, 4'hF);
        access(1'b0, 32'h8F00_0020, 0, 0);
        access(1'b0, 32'h8FFF_F020 - 32'h0000_F000 + 32'h0000_F000, 0, 0);
        // R9 zero write ignored
        set_base(8'h00);
        access(1'b0, 32'h8F00_0020, 0, 0);
        access(1'b0, 32'h0000_0000, 0, 0);
        // R9 move window
        set_base(8'h12);
        access(1'b0, 32'h1200_0020, 0, 0);
        access(1'b0, 32'h8F00_0020, 0, 0);
        set_base(8'h8F);

        // Random mix
        for (int t = 0; t < 600; t++) begin
            logic [31:0] a;
            if ($urandom_range(3) == 0) cfg_mask = ($urandom_range(2) == 0) ? 16'h0 : 16'($urandom);
            ext_cacheable = 1'($urandom);
            a = $urandom;
            if ($urandom_range(1) == 0) a[31:24] = m_base;
            a[1:0] = 2'b00;
            access(1'($urandom), a, $urandom, 4'($urandom));
            if ($urandom_range(7) == 0) begin
                @(negedge clk);
                check("R10 rsp_valid after gap", 32'(rsp_valid), 32'h0);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule